// File: doc/BRIEF.md
# Synchronous Burst Read Sequencer

This block sits on the memory side of a 32-bit, 512K-word array and serves synchronous burst reads. A host drives a burst clock, a chip enable, a latch enable, an advance strobe and the two output controls. The block captures a start address into its internal burst counter and waits a programmable number of valid burst-clock edges. It then presents one array word per data cycle and steps the counter while advance is held active. It fetches from the array through a one-cycle synchronous read port.

The burst clock is sampled by the block's own system clock `clk`. A configuration word is captured while reset is asserted and holds: the initial latency, which burst-clock edge counts as valid, the data rate (every valid edge or every second valid edge), and when the ready output is timed. Each time the counter steps into a new aligned group of four words, the block inserts one wait data cycle and signals it on `rdy`. The data outputs can be turned off while the counter keeps moving. A burst can also be parked and resumed without losing its place.

Top module: `burst_read_seq`

## Requirements
- R1: While reset is asserted and after it is released with chip enable high, `dq_en` is 0, `dq` is 0 and `rdy` is 1. `cfg_word` is captured during reset: bits [2:0] latency L, bit 3 falling-edge select, bit 4 half rate, bit 5 early ready.
- R2: With `ce_n` low, the start address `addr` is latched on the first valid burst-clock edge seen while `le_n` is low. If no valid edge occurs in that window, it is latched on the rising edge of `le_n`. Further valid edges inside the same low window do not restart the burst.
- R3: A valid edge is a 0-to-1 transition of `bclk` when cfg bit 3 is 0, and a 1-to-0 transition when it is 1. Transitions of the other polarity have no effect.
- R4: The first word, the array word at the start address, is presented on the L-th valid edge after the latch. An edge latch counts as edge 0; after a latch-enable latch, the next valid edge is edge 1. L values below 2 act as 2. Until that edge, `dq_en` is 0.
- R5: After the first word, each data edge with `adv_n` low and no wait presents the word at the next address. When `adv_n` is high, the counter and the presented word are held.
- R6: With cfg bit 4 set, data edges are every second valid edge after the first word. Otherwise every valid edge is a data edge.
- R7: When the presented address ends in binary 11, the first data edge with `adv_n` low presents no new word and leaves the counter unchanged. The following such edge steps the counter.
- R8: With cfg bit 5 clear, `rdy` is 0 from a wait edge until the next data edge. With it set, `rdy` is 0 from the moment the presented address ends in 11 with the wait still pending, until the wait edge.
- R9: Stepping from address 7FFFFh gives address 0 and the burst continues.
- R10: `dq_en` is 1 only when a burst has presented its first word, `ce_n` and `oe_n` are low and `od_n` is high. `dq` is 0 whenever `dq_en` is 0. The counter keeps stepping on data edges with `adv_n` low while the outputs are off.
- R11: With `adv_n` and `oe_n` both high the burst is parked. Driving `oe_n` low again shows the same word as before parking.
- R12: `ce_n` high ends any burst; from the next cycle `dq_en` is 0 and a new latch is needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples all inputs |
| rst_n | input | 1 | Active-low reset; configuration captured while low |
| cfg_word | input | 6 | Configuration word (latency, edge, rate, ready timing) |
| bclk | input | 1 | Burst clock from the host |
| ce_n | input | 1 | Chip enable, active low |
| le_n | input | 1 | Latch enable, active low |
| adv_n | input | 1 | Burst advance, active low |
| oe_n | input | 1 | Output enable, active low |
| od_n | input | 1 | Output disable, active low |
| addr | input | 19 | Burst start address |
| mem_addr | output | 19 | Array read address |
| mem_rdata | input | 32 | Array read data, one cycle after `mem_addr` |
| dq | output | 32 | Burst data word, zero when not driven |
| dq_en | output | 1 | Data output drive enable |
| rdy | output | 1 | Valid data ready; low marks a wait cycle |

## Verification
The hardest situation to reach from the ports is a boundary wait that coincides with the wrap from the top address to zero, under half-rate and early-ready timing together. A stall at that point would hide an off-by-one in the wrap or in the phase of the wait. The stimulus reaches it by latching 7FFFDh through a latch-enable rising edge, with falling-edge selection, half rate and early ready configured. It then holds advance active through enough valid edges to cross the top address. A separate run hides the outputs while advancing and then parks the burst, so the counter's progress is only visible after output enable returns.

// File: rtl/brs_pkg.sv
package brs_pkg;

  localparam int LAT_W = 3;
  localparam int CFG_W = LAT_W + 3;
  localparam logic [LAT_W-1:0] LAT_MIN = LAT_W'(2);

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LAT  = 2'd1,
    ST_RUN  = 2'd2
  } brs_state_e;

  // packed: rdy_early is bit CFG_W-1, lat occupies the low LAT_W bits
  typedef struct packed {
    logic             rdy_early;
    logic             half_rate;
    logic             edge_fall;
    logic [LAT_W-1:0] lat;
  } brs_cfg_t;

  // latency below the minimum is raised so the first fetch has time to land
  function automatic logic [LAT_W-1:0] eff_lat(input logic [LAT_W-1:0] l);
    return (l < LAT_MIN) ? LAT_MIN : l;
  endfunction

  // true once the count of edges already seen plus this edge meets latency
  function automatic logic lat_reached(input logic [LAT_W-1:0] seen,
                                       input logic [LAT_W-1:0] l);
    logic [LAT_W:0] nxt;
    nxt = {1'b0, seen} + 1'b1;
    return nxt >= {1'b0, eff_lat(l)};
  endfunction

endpackage

// File: rtl/brs_edge_detect.sv
module brs_edge_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic bclk,
  input  logic le_n,
  input  logic edge_fall,
  output logic vedge,
  output logic le_rise
);

  logic bclk_q;
  logic le_q;
  logic rise_s;
  logic fall_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bclk_q <= 1'b0;
      le_q   <= 1'b1;
    end else begin
      bclk_q <= bclk;
      le_q   <= le_n;
    end
  end

  assign rise_s  = bclk & ~bclk_q;
  assign fall_s  = ~bclk & bclk_q;
  assign vedge   = edge_fall ? fall_s : rise_s;
  assign le_rise = le_n & ~le_q;

endmodule

// File: rtl/brs_addr_counter.sv
module brs_addr_counter #(
  parameter int AW    = 19,
  parameter int BND_W = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] load_addr,
  input  logic          step,
  input  logic          run,
  output logic [AW-1:0] ctr,
  output logic [AW-1:0] mem_addr,
  output logic          at_bnd_end
);

  // wraps from the top of the space to zero by width truncation
  function automatic logic [AW-1:0] next_addr(input logic [AW-1:0] a);
    return AW'(a + 1'b1);
  endfunction

  // last word of an aligned group of 2**BND_W words
  function automatic logic group_end(input logic [AW-1:0] a);
    return &a[BND_W-1:0];
  endfunction

  logic [AW-1:0] ctr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    ctr_q <= '0;
    else if (load) ctr_q <= load_addr;
    else if (step) ctr_q <= next_addr(ctr_q);
  end

  assign ctr        = ctr_q;
  // during latency fetch the start word; while running prefetch the next one
  assign mem_addr   = run ? next_addr(ctr_q) : ctr_q;
  assign at_bnd_end = group_end(ctr_q);

endmodule

// File: rtl/brs_ctrl.sv
module brs_ctrl
  import brs_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  brs_cfg_t cfg,
  input  logic     vedge,
  input  logic     le_rise,
  input  logic     ce_n,
  input  logic     le_n,
  input  logic     adv_n,
  input  logic     at_bnd_end,
  output logic     start_ev,
  output logic     first_ev,
  output logic     step_ev,
  output logic     stall_ev,
  output logic     run,
  output logic     rdy
);

  brs_state_e       st_q;
  logic             lat_done_q;
  logic [LAT_W-1:0] lcnt_q;
  logic             ph_q;
  logic             waited_q;
  logic             rdy_late_q;

  logic dedge;
  logic wpend;
  logic live;

  assign run   = (st_q == ST_RUN);
  assign live  = !ce_n && !start_ev;

  // one latch per low window of le_n; le_rise implies le_n is high
  assign start_ev = !ce_n && !lat_done_q && ((!le_n && vedge) || le_rise);

  assign first_ev = live && (st_q == ST_LAT) && vedge && lat_reached(lcnt_q, cfg.lat);
  assign dedge    = run && vedge && (!cfg.half_rate || ph_q);
  assign wpend    = run && at_bnd_end && !waited_q;
  assign step_ev  = live && dedge && !adv_n && !wpend;
  assign stall_ev = live && dedge && !adv_n && wpend;

  assign rdy = cfg.rdy_early ? !wpend : rdy_late_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= ST_IDLE;
      lat_done_q <= 1'b0;
      lcnt_q     <= '0;
      ph_q       <= 1'b0;
      waited_q   <= 1'b0;
      rdy_late_q <= 1'b1;
    end else if (ce_n) begin
      st_q       <= ST_IDLE;
      lat_done_q <= 1'b0;
      waited_q   <= 1'b0;
      rdy_late_q <= 1'b1;
    end else if (start_ev) begin
      st_q       <= ST_LAT;
      lat_done_q <= 1'b1;
      lcnt_q     <= '0;
      ph_q       <= 1'b0;
      waited_q   <= 1'b0;
      rdy_late_q <= 1'b1;
    end else begin
      if (le_n) lat_done_q <= 1'b0;
      if ((st_q == ST_LAT) && vedge) begin
        if (first_ev) begin
          st_q <= ST_RUN;
          ph_q <= 1'b0;
        end else begin
          lcnt_q <= lcnt_q + 1'b1;
        end
      end
      if (run && vedge) ph_q <= !ph_q;
      if (dedge) rdy_late_q <= !stall_ev;
      if (stall_ev)     waited_q <= 1'b1;
      else if (step_ev) waited_q <= 1'b0;
    end
  end

endmodule

// File: rtl/burst_read_seq.sv
module burst_read_seq
  import brs_pkg::*;
#(
  parameter int AW    = 19,
  parameter int DW    = 32,
  parameter int BND_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CFG_W-1:0] cfg_word,
  input  logic             bclk,
  input  logic             ce_n,
  input  logic             le_n,
  input  logic             adv_n,
  input  logic             oe_n,
  input  logic             od_n,
  input  logic [AW-1:0]    addr,
  output logic [AW-1:0]    mem_addr,
  input  logic [DW-1:0]    mem_rdata,
  output logic [DW-1:0]    dq,
  output logic             dq_en,
  output logic             rdy
);

  brs_cfg_t      cfg_q;
  logic [DW-1:0] dq_q;
  logic [AW-1:0] ctr;

  // named internal events for the checker
  logic vedge;
  logic le_rise;
  logic start_ev;
  logic first_ev;
  logic step_ev;
  logic stall_ev;
  logic run;
  logic at_bnd_end;
  logic cfg_rdy_early;

  // configuration follows cfg_word while reset is held, frozen afterwards
  always_ff @(posedge clk) begin
    if (!rst_n) cfg_q <= brs_cfg_t'(cfg_word);
  end

  assign cfg_rdy_early = cfg_q.rdy_early;

  brs_edge_detect u_edge (
    .clk      (clk),
    .rst_n    (rst_n),
    .bclk     (bclk),
    .le_n     (le_n),
    .edge_fall(cfg_q.edge_fall),
    .vedge    (vedge),
    .le_rise  (le_rise)
  );

  brs_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg       (cfg_q),
    .vedge     (vedge),
    .le_rise   (le_rise),
    .ce_n      (ce_n),
    .le_n      (le_n),
    .adv_n     (adv_n),
    .at_bnd_end(at_bnd_end),
    .start_ev  (start_ev),
    .first_ev  (first_ev),
    .step_ev   (step_ev),
    .stall_ev  (stall_ev),
    .run       (run),
    .rdy       (rdy)
  );

  brs_addr_counter #(.AW(AW), .BND_W(BND_W)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (start_ev),
    .load_addr (addr),
    .step      (step_ev),
    .run       (run),
    .ctr       (ctr),
    .mem_addr  (mem_addr),
    .at_bnd_end(at_bnd_end)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    dq_q <= '0;
    else if (first_ev || step_ev)  dq_q <= mem_rdata;
  end

  assign dq_en = run && !ce_n && !oe_n && od_n;
  assign dq    = dq_en ? dq_q : '0;

endmodule

// File: rtl/burst_read_seq_chk.sv
module burst_read_seq_chk #(
  parameter int AW = 19
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ce_n,
  input logic          adv_n,
  input logic          dq_en,
  input logic          rdy,
  input logic          rdy_early,
  input logic          start_ev,
  input logic          step_ev,
  input logic          stall_ev,
  input logic [AW-1:0] ctr
);

  // R5 and R9: a step moves the counter by one, wrapping at the top
  a_r5_step_moves_one: assert property (@(posedge clk) disable iff (!rst_n)
    step_ev |=> ctr == AW'($past(ctr) + 1'b1));

  // R5 and R11: with advance inactive the counter holds unless a new latch occurs
  a_r11_adv_high_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_n && !start_ev) |=> $stable(ctr));

  // R7: a wait edge leaves the counter where it was
  a_r7_stall_holds: assert property (@(posedge clk) disable iff (!rst_n)
    stall_ev |=> $stable(ctr));

  // R7: a wait edge is never also a step edge
  a_r7_stall_excl_step: assert property (@(posedge clk) disable iff (!rst_n)
    !(stall_ev && step_ev));

  // R8: in late ready mode the wait is reported after the wait edge
  a_r8_late_rdy_low: assert property (@(posedge clk) disable iff (!rst_n)
    (stall_ev && !rdy_early) |=> !rdy);

  // R12: chip enable high turns the outputs off
  a_r12_ce_high_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    ce_n |=> !dq_en);

  // R4: outputs stay off right after a latch
  a_r4_quiet_after_latch: assert property (@(posedge clk) disable iff (!rst_n)
    start_ev |=> !dq_en);

endmodule

bind burst_read_seq burst_read_seq_chk #(.AW(AW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .ce_n     (ce_n),
  .adv_n    (adv_n),
  .dq_en    (dq_en),
  .rdy      (rdy),
  .rdy_early(cfg_rdy_early),
  .start_ev (start_ev),
  .step_ev  (step_ev),
  .stall_ev (stall_ev),
  .ctr      (ctr)
);

// File: tb/burst_read_seq_bench.sv
module burst_read_seq_bench;

  localparam int AW = 19;
  localparam int DW = 32;
  localparam int CW = 6;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [CW-1:0] cfg_word;
  logic          bclk, ce_n, le_n, adv_n, oe_n, od_n;
  logic [AW-1:0] addr;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_rdata;
  logic [DW-1:0] dq;
  logic          dq_en;
  logic          rdy;

  int n_vec  = 0;
  int n_fail = 0;
  bit done   = 1'b0;
  string cur_req = "R1";

  always #4 clk = ~clk;

  burst_read_seq u_burst_read_seq (
    .clk(clk), .rst_n(rst_n), .cfg_word(cfg_word), .bclk(bclk), .ce_n(ce_n),
    .le_n(le_n), .adv_n(adv_n), .oe_n(oe_n), .od_n(od_n), .addr(addr),
    .mem_addr(mem_addr), .mem_rdata(mem_rdata), .dq(dq), .dq_en(dq_en), .rdy(rdy)
  );

  function automatic logic [DW-1:0] memfun(input logic [AW-1:0] a);
    return {13'h15A3, a};
  endfunction

  always @(posedge clk) mem_rdata <= memfun(mem_addr);

  // ---------------- reference model (from the requirements) ----------------
  typedef struct {
    logic          en;
    logic [DW-1:0] d;
    logic          r;
  } exp_t;
  exp_t sbq[$];

  int            m_st;      // 0 idle, 1 latency, 2 running
  logic          m_bq, m_leq, m_latd, m_ph, m_wt, m_rl;
  int            m_lc;
  logic [AW-1:0] m_a;

  always @(posedge clk) begin
    logic rise, lrise, fall_mode, half, early, start, dat;
    int   leff;
    exp_t e;
    fall_mode = cfg_word[3];
    half      = cfg_word[4];
    early     = cfg_word[5];
    leff      = (cfg_word[2:0] < 3'd2) ? 2 : int'(cfg_word[2:0]);
    if (!rst_n) begin
      m_st = 0; m_bq = 1'b0; m_leq = 1'b1; m_latd = 1'b0; m_ph = 1'b0;
      m_wt = 1'b0; m_rl = 1'b1; m_lc = 0; m_a = '0;
    end else begin
      rise  = fall_mode ? (m_bq && !bclk) : (!m_bq && bclk);
      lrise = le_n && !m_leq;
      m_bq  = bclk;
      m_leq = le_n;
      if (ce_n) begin
        m_st = 0; m_latd = 1'b0; m_wt = 1'b0; m_rl = 1'b1;
      end else begin
        start = !m_latd && ((!le_n && rise) || lrise);
        if (start) begin
          m_st = 1; m_a = addr; m_lc = 0; m_latd = 1'b1; m_ph = 1'b0;
          m_wt = 1'b0; m_rl = 1'b1;
        end else begin
          if (le_n) m_latd = 1'b0;
          if (m_st == 1 && rise) begin
            if (m_lc + 1 >= leff) begin m_st = 2; m_ph = 1'b0; end
            else m_lc++;
          end else if (m_st == 2 && rise) begin
            dat  = !half || m_ph;
            m_ph = !m_ph;
            if (dat) begin
              if (!adv_n && m_a[1:0] == 2'b11 && !m_wt) begin
                m_wt = 1'b1; m_rl = 1'b0;
              end else begin
                m_rl = 1'b1;
                if (!adv_n) begin m_a = m_a + 1'b1; m_wt = 1'b0; end
              end
            end
          end
        end
      end
      e.en = (m_st == 2) && !ce_n && !oe_n && od_n;
      e.d  = e.en ? memfun(m_a) : '0;
      e.r  = early ? !((m_st == 2) && m_a[1:0] == 2'b11 && !m_wt) : m_rl;
      sbq.push_back(e);
    end
  end

  // ---------------- monitor ----------------
  bit saw_zero_word = 1'b0;
  int rdy_lows = 0;

  always @(posedge clk) begin
    exp_t e;
    #2;
    if (!done && sbq.size() > 0) begin
      e = sbq.pop_front();
      n_vec++;
      if (dq_en !== e.en || dq !== e.d || rdy !== e.r) begin
        n_fail++;
        $display("FAIL %s: dq_en/dq/rdy = %0b/%h/%0b expected %0b/%h/%0b",
                 cur_req, dq_en, dq, rdy, e.en, e.d, e.r);
      end
      if (dq_en && dq == memfun('0)) saw_zero_word = 1'b1;
      if (!rdy) rdy_lows++;
    end
  end

  task automatic check(input bit ok, input string req, input logic [DW-1:0] act,
                       input logic [DW-1:0] exp);
    n_vec++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // ---------------- driver ----------------
  logic act_lvl;

  task automatic do_reset(input logic [CW-1:0] c);
    @(negedge clk);
    rst_n = 1'b0; cfg_word = c; act_lvl = !c[3]; bclk = c[3];
    ce_n = 1'b1; le_n = 1'b1; adv_n = 1'b1; oe_n = 1'b1; od_n = 1'b1; addr = '0;
    repeat (3) @(negedge clk);
    // R1: quiet outputs during reset
    check(!dq_en && dq == '0 && rdy, "R1", {dq_en, rdy}, 2'b01);
    rst_n = 1'b1;
  endtask

  task automatic pulse(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); bclk = act_lvl;
      @(negedge clk); bclk = !act_lvl;
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic latch_on_edge(input logic [AW-1:0] a);
    @(negedge clk); ce_n = 1'b0; le_n = 1'b0; addr = a;
    pulse(1);
    @(negedge clk); le_n = 1'b1;
  endtask

  logic [DW-1:0] held;

  initial begin
    rst_n = 1'b0;
    // ---- run 1: rising edge, full rate, late ready, L = 3
    cur_req = "R1";
    do_reset(6'b000_011);
    idle(4);
    cur_req = "R2";
    latch_on_edge(19'h00010);
    cur_req = "R4";
    oe_n = 1'b0; adv_n = 1'b1;
    pulse(3);                                   // first word on third edge
    check(dq_en && dq == memfun(19'h10), "R4", dq, memfun(19'h10));
    cur_req = "R5";
    adv_n = 1'b0;
    pulse(3);                                   // 11,12,13
    check(dq == memfun(19'h13), "R5", dq, memfun(19'h13));
    cur_req = "R7";
    rdy_lows = 0;
    pulse(1);                                   // wait edge
    check(dq == memfun(19'h13), "R7", dq, memfun(19'h13));
    check(rdy_lows > 0, "R8", DW'(rdy_lows), 1);
    pulse(1);
    check(dq == memfun(19'h14), "R7", dq, memfun(19'h14));
    cur_req = "R3";
    @(negedge clk); bclk = 1'b1; idle(2);       // rising edge (valid)
    @(negedge clk); bclk = 1'b0; idle(2);       // falling edge ignored
    check(dq == memfun(19'h15), "R3", dq, memfun(19'h15));
    cur_req = "R10";
    od_n = 1'b0;
    pulse(2);                                   // 16,17 hidden
    check(!dq_en && dq == '0, "R10", dq, '0);
    od_n = 1'b1;
    idle(1);
    check(dq == memfun(19'h17), "R10", dq, memfun(19'h17));
    cur_req = "R11";
    held = dq;
    @(negedge clk); adv_n = 1'b1; oe_n = 1'b1;
    pulse(4);
    @(negedge clk); oe_n = 1'b0;
    idle(1);
    check(dq_en && dq == held, "R11", dq, held);
    adv_n = 1'b0;
    cur_req = "R12";
    @(negedge clk); ce_n = 1'b1;
    idle(2);
    check(!dq_en, "R12", DW'(dq_en), 0);
    @(negedge clk); ce_n = 1'b0;
    pulse(3);                                   // no latch -> stays quiet
    check(!dq_en, "R12", DW'(dq_en), 0);

    // ---- run 2: falling edge, half rate, early ready, L = 5, latch on le rise
    cur_req = "R6";
    do_reset(6'b111_101);
    idle(2);
    @(negedge clk); ce_n = 1'b0; le_n = 1'b0; addr = 19'h7FFFD; oe_n = 1'b0; adv_n = 1'b0;
    idle(2);
    cur_req = "R2";
    @(negedge clk); le_n = 1'b1;               // latch on le_n rise
    pulse(5);
    check(dq_en && dq == memfun(19'h7FFFD), "R2", dq, memfun(19'h7FFFD));
    cur_req = "R6";
    pulse(1);                                   // non-data edge
    check(dq == memfun(19'h7FFFD), "R6", dq, memfun(19'h7FFFD));
    pulse(1);
    check(dq == memfun(19'h7FFFE), "R6", dq, memfun(19'h7FFFE));
    cur_req = "R9";
    saw_zero_word = 1'b0;
    pulse(12);
    check(saw_zero_word, "R9", DW'(saw_zero_word), 1);

    // ---- run 3: latency field 1 acts as 2
    cur_req = "R4";
    do_reset(6'b000_001);
    idle(2);
    latch_on_edge(19'h00022);
    oe_n = 1'b0; adv_n = 1'b1;
    pulse(1);
    check(!dq_en, "R4", DW'(dq_en), 0);
    pulse(1);
    check(dq_en && dq == memfun(19'h22), "R4", dq, memfun(19'h22));
    idle(3);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      done = 1'b1;
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
    end
  end

endmodule